// File: doc/BRIEF.md
# Configuration-to-User Start-Up Sequencer

This block moves a programmable device from configuration into user operation. After the initialization input goes high it counts start-up clock rising edges and compares the count with a loaded length value. Start-up begins once the count has reached that value and the end-of-configuration frame flag is set. The block then schedules three events: it stops pulling the shared open-drain DONE line low, it releases the global set/reset of user flip-flops, and it enables the user I/O. Each event has its own delay setting, so the three can occur in any order or together.

In the synchronized mode the reset-release and I/O-enable delays are not counted from the block's own schedule. They start when the sensed DONE line is seen to go high. The line is a wired-AND of every device that shares it, so any device that holds it low stalls those two events. In the free-running mode the sensed line level is ignored. The start-up clock is a single input, whether the system feeds it from the configuration clock or from a user clock. The mode and delay inputs must stay stable while initialization is high.

Top module: `startup_sequencer`

## Requirements
- R1: While reset is applied, and on the first clock edge after `init_i` is sampled low, the outputs take the configuration state: `done_drive_o`=1 (DONE pulled low), `gsr_o`=1 (set/reset asserted) and `io_en_o`=0.
- R2: Rising edges are numbered from the first edge at which `init_i` is high. Start-up begins at edge S = max(L, F) + 1, where L is `len_count_i` and F is the edge after which `end_frame_i` is first sampled high (F=0 if it is high from the start). No output leaves the configuration state before edge S+1.
- R3: `done_drive_o` falls at edge S + 1 + d, where d is the DONE delay setting. With a setting of 0, DONE is released on the first start-up edge after S.
- R4: When `sync_mode_i`=0, `gsr_o` falls at edge S + 1 + g and `io_en_o` rises at edge S + 1 + i, where g and i are their delay settings. The level on `done_pin_i` has no effect on either.
- R5: When `sync_mode_i`=1, `done_pin_i` passes through two synchronizing flops and then a rise detector. If the line goes high just after edge P, the rise is taken at edge P+3. `gsr_o` then falls at edge P+3+g and `io_en_o` rises at edge P+3+i.
- R6: When `sync_mode_i`=1, neither `gsr_o` nor `io_en_o` leaves its configuration value while an external agent holds the DONE line low, for as long as the hold lasts.
- R7: Every 3-bit delay setting above 4 behaves as 4.
- R8: Once an event has taken effect it stays in effect while `init_i` stays high, whatever `done_pin_i` does afterwards.
- R9: The three events are timed independently. Any of them may come before, after or at the same edge as the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Start-up clock (configuration or user clock, chosen outside) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Initialization level; low forces the configuration state |
| len_count_i | input | LEN_W | Number of edges after `init_i` rises before start-up may begin |
| end_frame_i | input | 1 | End-of-configuration frame has been written |
| done_pin_i | input | 1 | Sensed level of the shared wired-AND DONE line |
| sync_mode_i | input | 1 | 1: reset and I/O events follow the sensed DONE rise; 0: edge count only |
| done_dly_i | input | DLY_W | Extra edges after the first start-up edge before DONE is released |
| gsr_dly_i | input | DLY_W | Delay setting for the set/reset release |
| io_dly_i | input | DLY_W | Delay setting for the I/O enable |
| done_drive_o | output | 1 | 1 pulls the DONE line low, 0 releases it |
| gsr_o | output | 1 | Global set/reset, active high |
| io_en_o | output | 1 | User I/O enable, active high |

## Verification
The bench goes after off-by-one timing. The edge at which the length match turns into start-up, the first start-up edge that releases DONE, and the three-edge latency of synchronizer plus rise detector all need exact sampling. A design that miscounted any of them would release an output one edge early or late. Late end-frame arrival, zero length count and delay settings of 5 to 7 are covered. A design that ignored the frame flag, treated zero as a wrap or failed to saturate would release at a different edge from the one expected. In synchronized mode the line is held low externally, first for a long time and later as a glitch after start-up. A design that read the pin in free-running mode, or let a later low pulse re-arm the events, would either stall or drop an output back.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

   typedef enum logic [1:0] {
      ST_CONFIG  = 2'd0,
      ST_STARTUP = 2'd1,
      ST_RUN     = 2'd2
   } seq_state_e;

   localparam int unsigned N_EVENTS = 3;
   localparam int unsigned EV_DONE  = 0;
   localparam int unsigned EV_GSR   = 1;
   localparam int unsigned EV_IO    = 2;

endpackage

// File: rtl/cfg_len_counter.sv
module cfg_len_counter #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             init_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             reached_o
);

   logic [LEN_W-1:0] edge_cnt;

   // counts edges with init high, holding once the length is reached
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         edge_cnt <= '0;
      end else if (!init_i) begin
         edge_cnt <= '0;
      end else if (edge_cnt < len_i) begin
         edge_cnt <= edge_cnt + 1'b1;
      end
   end

   assign reached_o = init_i && (edge_cnt == len_i);

endmodule

// File: rtl/done_sense.sv
module done_sense #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic rise_o
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], pin_i};
         last_q <= chain[STAGES-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/event_timer.sv
module event_timer #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             fired_o
);

   logic             running;
   logic [CNT_W-1:0] elapsed;

   // fires target_i edges after the edge that samples start_i
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         running <= 1'b0;
         elapsed <= '0;
         fired_o <= 1'b0;
      end else if (clr_i) begin
         running <= 1'b0;
         elapsed <= '0;
         fired_o <= 1'b0;
      end else if (!fired_o && !running && start_i) begin
         if (target_i == '0) begin
            fired_o <= 1'b1;
         end else begin
            running <= 1'b1;
            elapsed <= '0;
         end
      end else if (running) begin
         if ((elapsed + 1'b1) == target_i) begin
            fired_o <= 1'b1;
            running <= 1'b0;
         end else begin
            elapsed <= elapsed + 1'b1;
         end
      end
   end

endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
   import startup_seq_pkg::*;
#(
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned DLY_W       = 3,
   parameter int unsigned MAX_DELAY   = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             init_i,
   input  logic [LEN_W-1:0] len_count_i,
   input  logic             end_frame_i,
   input  logic             done_pin_i,
   input  logic             sync_mode_i,
   input  logic [DLY_W-1:0] done_dly_i,
   input  logic [DLY_W-1:0] gsr_dly_i,
   input  logic [DLY_W-1:0] io_dly_i,
   output logic             done_drive_o,
   output logic             gsr_o,
   output logic             io_en_o
);

   localparam int unsigned TGT_W = $clog2(MAX_DELAY + 2);

   if (SYNC_STAGES < 2 || MAX_DELAY < 1 || LEN_W < 1 || DLY_W < 1) begin : g_param_check
      $error("startup_sequencer: illegal parameter set");
   end

   function automatic logic [TGT_W-1:0] clamp_dly(input logic [DLY_W-1:0] raw);
      if (int'(raw) > int'(MAX_DELAY)) begin
         return TGT_W'(MAX_DELAY);
      end
      return TGT_W'(raw);
   endfunction

   seq_state_e          state_q;
   logic                reached;
   logic                done_rise;
   logic                start_pulse;
   logic                clr;
   logic [N_EVENTS-1:0] fired;
   logic [N_EVENTS-1:0] ev_start;
   logic [TGT_W-1:0]    ev_target [N_EVENTS];
   logic [DLY_W-1:0]    ev_raw    [N_EVENTS];

   assign clr         = !init_i;
   assign start_pulse = (state_q == ST_CONFIG) && reached && end_frame_i;

   assign ev_raw[EV_DONE] = done_dly_i;
   assign ev_raw[EV_GSR]  = gsr_dly_i;
   assign ev_raw[EV_IO]   = io_dly_i;

   cfg_len_counter #(
      .LEN_W (LEN_W)
   ) u_len_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .init_i    (init_i),
      .len_i     (len_count_i),
      .reached_o (reached)
   );

   done_sense #(
      .STAGES (SYNC_STAGES)
   ) u_done_sense (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (done_pin_i),
      .rise_o (done_rise)
   );

   for (genvar k = 0; k < N_EVENTS; k++) begin : g_event
      if (k == EV_DONE) begin : g_self
         // DONE counts from the first start-up edge
         assign ev_start[k]  = start_pulse;
         assign ev_target[k] = clamp_dly(ev_raw[k]) + 1'b1;
      end else begin : g_follow
         // reset release and I/O enable: free-running or tied to the sensed line
         assign ev_start[k]  = sync_mode_i ? (done_rise && fired[EV_DONE]) : start_pulse;
         assign ev_target[k] = sync_mode_i ? clamp_dly(ev_raw[k])
                                           : clamp_dly(ev_raw[k]) + 1'b1;
      end

      event_timer #(
         .CNT_W (TGT_W)
      ) u_timer (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .clr_i    (clr),
         .start_i  (ev_start[k]),
         .target_i (ev_target[k]),
         .fired_o  (fired[k])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_CONFIG;
      end else if (clr) begin
         state_q <= ST_CONFIG;
      end else begin
         unique case (state_q)
            ST_CONFIG:  if (start_pulse) state_q <= ST_STARTUP;
            ST_STARTUP: if (&fired)      state_q <= ST_RUN;
            ST_RUN:     state_q <= ST_RUN;
            default:    state_q <= ST_CONFIG;
         endcase
      end
   end

   assign done_drive_o = !fired[EV_DONE];
   assign gsr_o        = !fired[EV_GSR];
   assign io_en_o      = fired[EV_IO];

endmodule

// File: rtl/startup_sequencer_chk.sv
module startup_sequencer_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic init_i,
   input logic sync_mode_i,
   input logic done_drive_o,
   input logic gsr_o,
   input logic io_en_o
);

   p_init_low_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !init_i |=> (done_drive_o && gsr_o && !io_en_o));

   p_release_needs_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(done_drive_o) |-> $past(init_i));

   p_gsr_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_i && sync_mode_i && !gsr_o) |-> !done_drive_o);

   p_io_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_i && sync_mode_i && io_en_o) |-> !done_drive_o);

   p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_i && !done_drive_o) |=> !done_drive_o);

   p_gsr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_i && !gsr_o) |=> !gsr_o);

   p_io_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_i && io_en_o) |=> io_en_o);

endmodule

bind startup_sequencer startup_sequencer_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .init_i       (init_i),
   .sync_mode_i  (sync_mode_i),
   .done_drive_o (done_drive_o),
   .gsr_o        (gsr_o),
   .io_en_o      (io_en_o)
);

// File: tb/startup_sequencer_tb.sv
module startup_sequencer_tb;

   localparam int LEN_W = 16;
   localparam int DLY_W = 3;

   typedef struct packed {
      int len;
      int dd;
      int gd;
      int id;
      int sy;
      int hrel;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{5, 0, 0, 0, 0, 0},
      '{3, 2, 0, 4, 0, 0},
      '{0, 4, 1, 3, 0, 0},
      '{4, 7, 6, 5, 0, 0},
      '{2, 0, 0, 0, 1, 0},
      '{6, 1, 2, 0, 1, 20},
      '{1, 3, 4, 4, 1, 0},
      '{7, 0, 7, 1, 1, 15}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             init = 1'b0;
   logic [LEN_W-1:0] len_cnt = '0;
   logic             end_frame = 1'b0;
   logic             sync_mode = 1'b0;
   logic [DLY_W-1:0] done_dly = '0;
   logic [DLY_W-1:0] gsr_dly = '0;
   logic [DLY_W-1:0] io_dly = '0;
   logic             ext_hold = 1'b0;
   logic             done_drive;
   logic             gsr;
   logic             io_en;
   logic             done_pin;

   int checks = 0;
   int fails  = 0;
   int fd, fg, fi, reverts;

   always #4 clk = ~clk;

   // shared open-drain line: low if this block or an external agent pulls it
   assign done_pin = !(done_drive || ext_hold);

   startup_sequencer #(
      .LEN_W (LEN_W),
      .DLY_W (DLY_W)
   ) u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .init_i       (init),
      .len_count_i  (len_cnt),
      .end_frame_i  (end_frame),
      .done_pin_i   (done_pin),
      .sync_mode_i  (sync_mode),
      .done_dly_i   (done_dly),
      .gsr_dly_i    (gsr_dly),
      .io_dly_i     (io_dly),
      .done_drive_o (done_drive),
      .gsr_o        (gsr),
      .io_en_o      (io_en)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int sat(input int d);
      return (d > 4) ? 4 : d;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // one start-up run; records the edge after which each output first left its config value
   task automatic run_seq(input int len, input int dd, input int gd, input int idl,
                          input int sy, input int hrel, input int ef,
                          input int glitch, input int nedges);
      @(negedge clk);
      init      = 1'b0;
      len_cnt   = LEN_W'(len);
      done_dly  = DLY_W'(dd);
      gsr_dly   = DLY_W'(gd);
      io_dly    = DLY_W'(idl);
      sync_mode = (sy != 0);
      end_frame = (ef == 0);
      ext_hold  = (hrel > 0);
      @(negedge clk);
      @(negedge clk);
      init    = 1'b1;
      fd      = 0;
      fg      = 0;
      fi      = 0;
      reverts = 0;
      for (int n = 1; n <= nedges; n++) begin
         @(negedge clk);
         if (fd == 0 && !done_drive) fd = n;
         else if (fd != 0 && done_drive) reverts++;
         if (fg == 0 && !gsr) fg = n;
         else if (fg != 0 && gsr) reverts++;
         if (fi == 0 && io_en) fi = n;
         else if (fi != 0 && !io_en) reverts++;
         if (ef > 0 && n == ef) end_frame = 1'b1;
         ext_hold = (n < hrel) || (glitch > 0 && n >= glitch && n < glitch + 3);
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset done_drive", int'(done_drive), 1);
      check("R1 reset gsr", int'(gsr), 1);
      check("R1 reset io_en", int'(io_en), 0);
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R5 R6 R7 R9
      for (int v = 0; v < NVEC; v++) begin
         int s, x, eg, ei, r;
         run_seq(VECS[v].len, VECS[v].dd, VECS[v].gd, VECS[v].id,
                 VECS[v].sy, VECS[v].hrel, 0, 0, 40);
         s = VECS[v].len + 1;
         x = s + 1 + sat(VECS[v].dd);
         if (VECS[v].sy != 0) begin
            r  = imax(x, VECS[v].hrel) + 3;
            eg = r + sat(VECS[v].gd);
            ei = r + sat(VECS[v].id);
            check("R5/R6 gsr release edge", fg, eg);
            check("R5/R6 io enable edge", fi, ei);
         end else begin
            eg = s + 1 + sat(VECS[v].gd);
            ei = s + 1 + sat(VECS[v].id);
            check("R4/R7/R9 gsr release edge", fg, eg);
            check("R4/R7/R9 io enable edge", fi, ei);
         end
         check("R2/R3/R7 done release edge", fd, x);
      end

      // R2: end frame arrives late, start waits for it
      run_seq(2, 0, 0, 0, 0, 0, 10, 0, 20);
      check("R2 late frame done edge", fd, 12);
      check("R2 late frame gsr edge", fg, 12);

      // R4: free-running mode ignores a line held low forever
      run_seq(2, 0, 1, 0, 0, 1000, 0, 0, 20);
      check("R4 held line done edge", fd, 4);
      check("R4 held line gsr edge", fg, 5);
      check("R4 held line io edge", fi, 4);

      // R6 long hold in sync mode, then R8 glitch after start-up
      run_seq(2, 0, 0, 0, 1, 40, 0, 50, 60);
      check("R6 hold gsr edge", fg, 43);
      check("R6 hold io edge", fi, 43);
      check("R8 no output reverts on later glitch", reverts, 0);

      // R1/R8: dropping init returns to configuration state
      @(negedge clk);
      init = 1'b0;
      @(negedge clk);
      check("R1 init drop done_drive", int'(done_drive), 1);
      check("R1 init drop gsr", int'(gsr), 1);
      check("R1 init drop io_en", int'(io_en), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule